// File: doc/BRIEF.md
# ARP Next-Hop Resolution Controller

This block finds the Ethernet MAC address of the next hop before a tunnel is allowed to start. It takes the local MAC and IPv4 address, the remote IPv4 address, a CIDR prefix length and a gateway address. From these it decides whether the remote host sits on the local subnet or has to be reached through the gateway.

It then broadcasts an ARP request on a 64-bit byte-enabled transmit stream and watches a receive stream for a matching ARP reply. When no reply comes within the timeout, it sends the request again, up to a fixed bound. It ends in one of two ways: it holds the learned MAC address and raises a done flag, or it pulses a coded "unreachable" status.

The controller is a four-state machine:

- **IDLE**: waiting for a start strobe.
- **SEND**: presenting the request frame.
- **WAIT**: reply timer running.
- **DONE**: MAC resolved.

Its transitions are:

- *launch*: IDLE or DONE to SEND, on start.
- *sent*: SEND to WAIT, on acceptance of the last request beat.
- *hit*: WAIT to DONE, on a matching reply.
- *retry*: WAIT to SEND, on timeout with attempts left.
- *give-up*: WAIT to IDLE, on timeout after the final attempt.

Top module: `arp_nexthop_resolver`

## Requirements
- R1: After reset, `tx_valid_o`, `done_o`, `busy_o` and `status_valid_o` are 0, and `peer_mac_o` is 0.
- R2: A `start_i` pulse seen while the block is not busy (IDLE or DONE) begins a resolution. In the next cycle `busy_o` is 1, `done_o` is 0 and a request frame is presented. A `start_i` pulse seen while busy is ignored and sends no extra frame.
- R3: The ARP target is the gateway address exactly when the gateway is non-zero and the remote address is off-subnet. Otherwise the target is the remote address. With prefix length N (0..31), the remote address is on-subnet when its top N bits equal those of the local address. N = 0 always counts as off-subnet.
- R4: A request is 42 bytes sent as 6 beats, with byte i on `tx_data_o[8*(i%8)+:8]` of beat i/8. The byte layout is:
  - bytes 0-5: FF
  - bytes 6-11: local MAC, most significant byte first
  - bytes 12-13: 08 06
  - bytes 14-15: 00 01
  - bytes 16-17: 08 00
  - bytes 18-19: 06 04
  - bytes 20-21: 00 01
  - bytes 22-27: local MAC
  - bytes 28-31: local IP, most significant byte first
  - bytes 32-37: 00
  - bytes 38-41: target IP

  `tx_keep_o` is FF on beats 0-4 and 03 on beat 5. `tx_first_o` is set only on beat 0 and `tx_last_o` only on beat 5.
- R5: While `tx_valid_o` is 1 and `tx_ready_i` is 0, the transmit beat (valid, data, keep, first, last) is held unchanged.
- R6: In WAIT, a received frame is accepted when all of these hold:
  - it is at least 42 bytes long;
  - bytes 12-13 are 08 06, bytes 14-15 are 00 01, bytes 16-17 are 08 00 and bytes 18-19 are 06 04;
  - bytes 20-21 are 00 02;
  - bytes 28-31 equal the target IP.

  Acceptance sets `done_o` to 1 and `busy_o` to 0, and places bytes 22-27 on `peer_mac_o`, most significant byte first. It leaves `tx_valid_o` at 0.
- R7: A received frame is ignored in any of these cases:
  - it carries `rx_error_i` with its last beat;
  - its opcode is not 2;
  - its sender IP differs from the target.
- R8: If no reply is accepted, the first beat of the next request appears TIMEOUT_MS*CLK_PER_MS+1 cycles after the cycle in which the previous request's last beat was accepted.
- R9: At most 1 + MAX_RETRY requests (11 by default) are sent per resolution. If the last timeout expires without a reply, `status_o` becomes 0x0002 with a one-cycle `status_valid_o` pulse, and `busy_o` and `done_o` fall to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe |
| local_mac_i | input | 48 | Local MAC address |
| local_ip_i | input | 32 | Local IPv4 address |
| remote_ip_i | input | 32 | Remote IPv4 address |
| prefix_len_i | input | 5 | CIDR prefix length, 0..31 |
| gateway_ip_i | input | 32 | Gateway IPv4 address, 0 when absent |
| tx_valid_o | output | 1 | Transmit beat valid |
| tx_ready_i | input | 1 | Transmit beat accepted |
| tx_data_o | output | 64 | Transmit data |
| tx_keep_o | output | 8 | Transmit byte enables |
| tx_first_o | output | 1 | First beat of frame |
| tx_last_o | output | 1 | Last beat of frame |
| rx_valid_i | input | 1 | Receive beat valid |
| rx_data_i | input | 64 | Receive data |
| rx_keep_i | input | 8 | Receive byte enables |
| rx_last_i | input | 1 | Last beat of received frame |
| rx_error_i | input | 1 | Frame error, valid with last beat |
| busy_o | output | 1 | Resolution in progress |
| done_o | output | 1 | MAC resolved |
| peer_mac_o | output | 48 | Resolved next-hop MAC |
| status_o | output | 16 | Status code |
| status_valid_o | output | 1 | One-cycle status strobe |

## Verification
The hardest state to reach from the ports is the give-up path. It takes eleven full reply timeouts in a row with no accepted reply, and it must be told apart from a miscounted retry bound. The bench shrinks the timeout through the parameters to keep that run short. It counts every request frame its monitor sees, and checks that the unreachable strobe appears only after the eleventh. Near-miss replies are injected inside a wait window to show they do not end the wait early: wrong sender IP, wrong opcode, a flagged error, and a reply from the host the subnet test did not choose.

// File: rtl/arp_res_pkg.sv
package arp_res_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_DONE
    } res_state_t;

    localparam int          REQ_BEATS      = 6;
    localparam int          REQ_FLAT_W     = 64 * REQ_BEATS;
    localparam logic [7:0]  TAIL_KEEP      = 8'h03;
    localparam logic [15:0] CODE_UNREACHED = 16'h0002;

    // Request image, byte i at bits [8*i +: 8]; bytes past 41 are zero.
    function automatic logic [REQ_FLAT_W-1:0] build_request(
        input logic [47:0] own_mac,
        input logic [31:0] own_ip,
        input logic [31:0] want_ip
    );
        logic [7:0]            octet [REQ_BEATS*8];
        logic [REQ_FLAT_W-1:0] img;
        for (int i = 0; i < REQ_BEATS*8; i++) octet[i] = 8'h00;
        for (int i = 0; i < 6; i++) begin
            octet[i]      = 8'hFF;
            octet[6 + i]  = own_mac[47 - 8*i -: 8];
            octet[22 + i] = own_mac[47 - 8*i -: 8];
        end
        octet[12] = 8'h08; octet[13] = 8'h06;
        octet[15] = 8'h01;
        octet[16] = 8'h08;
        octet[18] = 8'h06; octet[19] = 8'h04;
        octet[21] = 8'h01;
        for (int i = 0; i < 4; i++) begin
            octet[28 + i] = own_ip[31 - 8*i -: 8];
            octet[38 + i] = want_ip[31 - 8*i -: 8];
        end
        for (int i = 0; i < REQ_BEATS*8; i++) img[8*i +: 8] = octet[i];
        return img;
    endfunction

endpackage

// File: rtl/arp_subnet_sel.sv
module arp_subnet_sel (
    input  logic [31:0] local_ip_i,
    input  logic [31:0] remote_ip_i,
    input  logic [4:0]  prefix_len_i,
    input  logic [31:0] gateway_ip_i,
    output logic [31:0] target_ip_o
);
    logic [31:0] net_mask;
    logic        same_net;

    always_comb begin
        net_mask    = (prefix_len_i == 5'd0) ? 32'h0 : ~(32'hFFFF_FFFF >> prefix_len_i);
        same_net    = (prefix_len_i != 5'd0) && (((local_ip_i ^ remote_ip_i) & net_mask) == 32'h0);
        target_ip_o = ((gateway_ip_i != 32'h0) && !same_net) ? gateway_ip_i : remote_ip_i;
    end
endmodule

// File: rtl/arp_req_tx.sv
module arp_req_tx
    import arp_res_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en_i,
    input  logic [REQ_FLAT_W-1:0] frame_i,
    input  logic                  ready_i,
    output logic                  valid_o,
    output logic [63:0]           data_o,
    output logic [7:0]            keep_o,
    output logic                  first_o,
    output logic                  last_o,
    output logic                  sent_o
);
    logic [2:0] beat_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            beat_q <= 3'd0;
        end else if (ready_i) begin
            beat_q <= last_o ? 3'd0 : beat_q + 3'd1;
        end
    end

    always_comb begin
        valid_o = en_i;
        last_o  = (beat_q == 3'(REQ_BEATS - 1));
        first_o = (beat_q == 3'd0);
        keep_o  = last_o ? TAIL_KEEP : 8'hFF;
        data_o  = frame_i[{beat_q, 6'b0} +: 64];
        sent_o  = en_i && ready_i && last_o;
    end
endmodule

// File: rtl/arp_reply_rx.sv
module arp_reply_rx (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid_i,
    input  logic [63:0] rx_data_i,
    input  logic [7:0]  rx_keep_i,
    input  logic        rx_last_i,
    input  logic        rx_error_i,
    input  logic [31:0] target_ip_i,
    output logic        hit_o,
    output logic [47:0] mac_o
);
    logic [2:0]  cnt_q;      // beat index, saturates at 6
    logic [31:0] w1_q;       // bytes 12..15
    logic [63:0] w2_q;       // bytes 16..23
    logic [63:0] w3_q;       // bytes 24..31
    logic        long_enough, good;
    logic [47:0] snd_mac;
    logic [31:0] snd_ip;

    always_comb begin
        long_enough = (cnt_q == 3'd6) || ((cnt_q == 3'd5) && (rx_keep_i >= 8'h03));
        snd_mac = {w2_q[55:48], w2_q[63:56], w3_q[7:0], w3_q[15:8], w3_q[23:16], w3_q[31:24]};
        snd_ip  = {w3_q[39:32], w3_q[47:40], w3_q[55:48], w3_q[63:56]};
        good = rx_valid_i && rx_last_i && !rx_error_i && long_enough
            && ({w1_q[7:0],   w1_q[15:8]}  == 16'h0806)
            && ({w1_q[23:16], w1_q[31:24]} == 16'h0001)
            && ({w2_q[7:0],   w2_q[15:8]}  == 16'h0800)
            && ({w2_q[23:16], w2_q[31:24]} == 16'h0604)
            && ({w2_q[39:32], w2_q[47:40]} == 16'h0002)
            && (snd_ip == target_ip_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= 3'd0;
            w1_q  <= '0;
            w2_q  <= '0;
            w3_q  <= '0;
            hit_o <= 1'b0;
            mac_o <= '0;
        end else begin
            hit_o <= good;
            if (good) mac_o <= snd_mac;
            if (rx_valid_i) begin
                if (cnt_q == 3'd1) w1_q <= rx_data_i[63:32];
                if (cnt_q == 3'd2) w2_q <= rx_data_i;
                if (cnt_q == 3'd3) w3_q <= rx_data_i;
                if (rx_last_i)          cnt_q <= 3'd0;
                else if (cnt_q != 3'd6) cnt_q <= cnt_q + 3'd1;
            end
        end
    end
endmodule

// File: rtl/arp_nexthop_resolver.sv
module arp_nexthop_resolver
    import arp_res_pkg::*;
#(
    parameter int CLK_PER_MS = 1000,
    parameter int TIMEOUT_MS = 100,
    parameter int MAX_RETRY  = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [47:0] local_mac_i,
    input  logic [31:0] local_ip_i,
    input  logic [31:0] remote_ip_i,
    input  logic [4:0]  prefix_len_i,
    input  logic [31:0] gateway_ip_i,
    output logic        tx_valid_o,
    input  logic        tx_ready_i,
    output logic [63:0] tx_data_o,
    output logic [7:0]  tx_keep_o,
    output logic        tx_first_o,
    output logic        tx_last_o,
    input  logic        rx_valid_i,
    input  logic [63:0] rx_data_i,
    input  logic [7:0]  rx_keep_i,
    input  logic        rx_last_i,
    input  logic        rx_error_i,
    output logic        busy_o,
    output logic        done_o,
    output logic [47:0] peer_mac_o,
    output logic [15:0] status_o,
    output logic        status_valid_o
);
    localparam int TIMEOUT_CYC = CLK_PER_MS * TIMEOUT_MS;
    localparam int TMW         = $clog2(TIMEOUT_CYC + 1);
    localparam int TRW         = $clog2(MAX_RETRY + 2);

    res_state_t      state_q, state_d;
    logic [TMW-1:0]  tmr_q;
    logic [TRW-1:0]  tries_q;
    logic [31:0]     sel_ip, tgt_q;
    logic            launch, expired, last_try, tx_sent, rx_hit;
    logic [47:0]     rx_mac;

    arp_subnet_sel u_sel (
        .local_ip_i  (local_ip_i),
        .remote_ip_i (remote_ip_i),
        .prefix_len_i(prefix_len_i),
        .gateway_ip_i(gateway_ip_i),
        .target_ip_o (sel_ip)
    );

    arp_req_tx u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (state_q == ST_SEND),
        .frame_i(build_request(local_mac_i, local_ip_i, tgt_q)),
        .ready_i(tx_ready_i),
        .valid_o(tx_valid_o),
        .data_o (tx_data_o),
        .keep_o (tx_keep_o),
        .first_o(tx_first_o),
        .last_o (tx_last_o),
        .sent_o (tx_sent)
    );

    arp_reply_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid_i (rx_valid_i),
        .rx_data_i  (rx_data_i),
        .rx_keep_i  (rx_keep_i),
        .rx_last_i  (rx_last_i),
        .rx_error_i (rx_error_i),
        .target_ip_i(tgt_q),
        .hit_o      (rx_hit),
        .mac_o      (rx_mac)
    );

    assign launch   = start_i && ((state_q == ST_IDLE) || (state_q == ST_DONE));
    assign expired  = (state_q == ST_WAIT) && (tmr_q == TMW'(TIMEOUT_CYC - 1));
    assign last_try = (tries_q == TRW'(MAX_RETRY));
    assign busy_o   = (state_q == ST_SEND) || (state_q == ST_WAIT);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: launch, sent, hit, retry, give-up
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: if (launch)  state_d = ST_SEND;
            ST_SEND:          if (tx_sent) state_d = ST_WAIT;
            ST_WAIT: begin
                if (rx_hit)       state_d = ST_DONE;
                else if (expired) state_d = last_try ? ST_IDLE : ST_SEND;
            end
            default:          state_d = ST_IDLE;
        endcase
    end

    // Timer, attempt count and latched target
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q   <= '0;
            tries_q <= '0;
            tgt_q   <= '0;
        end else begin
            tmr_q <= (state_q == ST_WAIT && !expired) ? tmr_q + TMW'(1) : '0;
            if (launch) begin
                tries_q <= '0;
                tgt_q   <= sel_ip;
            end else if (expired && !rx_hit && !last_try) begin
                tries_q <= tries_q + TRW'(1);
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o         <= 1'b0;
            peer_mac_o     <= '0;
            status_o       <= '0;
            status_valid_o <= 1'b0;
        end else begin
            done_o         <= (state_d == ST_DONE);
            status_valid_o <= 1'b0;
            if (state_q == ST_WAIT && rx_hit) peer_mac_o <= rx_mac;
            if (expired && !rx_hit && last_try) begin
                status_o       <= CODE_UNREACHED;
                status_valid_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/arp_res_checker.sv
module arp_res_checker #(
    parameter int ATTEMPTS = 11
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        busy_o,
    input logic        done_o,
    input logic        tx_valid_o,
    input logic        tx_ready_i,
    input logic [63:0] tx_data_o,
    input logic [7:0]  tx_keep_o,
    input logic        tx_first_o,
    input logic        tx_last_o,
    input logic [15:0] status_o,
    input logic        status_valid_o
);
    int sent_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                                  sent_cnt <= 0;
        else if (start_i && !busy_o)                 sent_cnt <= 0;
        else if (tx_valid_o && tx_ready_i && tx_last_o) sent_cnt <= sent_cnt + 1;
    end

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o |=> busy_o && !done_o);                               // R2
    AST_KEEP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o && !tx_last_o |-> tx_keep_o == 8'hFF);                        // R4
    AST_FRAME_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o |-> !(tx_first_o && tx_last_o));                              // R4
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o)
            && $stable(tx_keep_o) && $stable(tx_last_o) && $stable(tx_first_o)); // R5
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && !tx_valid_o);                                      // R6
    AST_SEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        sent_cnt <= ATTEMPTS);                                                   // R9
    AST_FAIL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        status_valid_o |-> sent_cnt == ATTEMPTS && status_o == 16'h0002);        // R9
    AST_STATUS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        status_valid_o |=> !status_valid_o);                                     // R9
endmodule

bind arp_nexthop_resolver arp_res_checker #(.ATTEMPTS(MAX_RETRY + 1)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .tx_valid_o    (tx_valid_o),
    .tx_ready_i    (tx_ready_i),
    .tx_data_o     (tx_data_o),
    .tx_keep_o     (tx_keep_o),
    .tx_first_o    (tx_first_o),
    .tx_last_o     (tx_last_o),
    .status_o      (status_o),
    .status_valid_o(status_valid_o)
);

// File: tb/arp_nexthop_resolver_bench.sv
module arp_nexthop_resolver_bench;
    localparam int CPM = 1000;
    localparam int TMS = 2;
    localparam int RETRIES = 10;
    localparam int T = CPM * TMS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [47:0] local_mac_i = '0;
    logic [31:0] local_ip_i = '0, remote_ip_i = '0, gateway_ip_i = '0;
    logic [4:0]  prefix_len_i = '0;
    logic        tx_valid_o, tx_first_o, tx_last_o;
    logic        tx_ready_i = 1'b1;
    logic [63:0] tx_data_o;
    logic [7:0]  tx_keep_o;
    logic        rx_valid_i = 1'b0, rx_last_i = 1'b0, rx_error_i = 1'b0;
    logic [63:0] rx_data_i = '0;
    logic [7:0]  rx_keep_i = '0;
    logic        busy_o, done_o, status_valid_o;
    logic [47:0] peer_mac_o;
    logic [15:0] status_o;

    arp_nexthop_resolver #(.CLK_PER_MS(CPM), .TIMEOUT_MS(TMS), .MAX_RETRY(RETRIES))
    u_arp_nexthop_resolver (.*);

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int frames_seen = 0, frames_done = 0, last_end_cyc = 0, last_gap = 0, mon_beat = 0;
    bit in_frame = 0, frame_bad = 0, rand_ready = 0, finished = 0;
    logic [47:0] exp_mac;
    logic [31:0] exp_lip, exp_tip;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pick_target(logic [31:0] lip, logic [31:0] rip, int plen, logic [31:0] gw);
        bit on = (plen != 0);
        for (int i = 0; i < 32; i++)
            if (i < plen && lip[31-i] != rip[31-i]) on = 0;
        return (gw != 0 && !on) ? gw : rip;
    endfunction

    function automatic logic [7:0] req_byte(int i);
        if (i < 6)  return 8'hFF;
        if (i < 12) return exp_mac[8*(11-i) +: 8];
        case (i)
            12: return 8'h08; 13: return 8'h06; 14: return 8'h00; 15: return 8'h01;
            16: return 8'h08; 17: return 8'h00; 18: return 8'h06; 19: return 8'h04;
            20: return 8'h00; 21: return 8'h01;
            default: ;
        endcase
        if (i < 28) return exp_mac[8*(27-i) +: 8];
        if (i < 32) return exp_lip[8*(31-i) +: 8];
        if (i < 38) return 8'h00;
        if (i < 42) return exp_tip[8*(41-i) +: 8];
        return 8'h00;
    endfunction

    function automatic logic [7:0] rep_byte(int i, logic [47:0] smac, logic [31:0] sip, logic [7:0] op);
        if (i < 6)  return exp_mac[8*(5-i) +: 8];
        if (i < 12) return smac[8*(11-i) +: 8];
        case (i)
            12: return 8'h08; 13: return 8'h06; 14: return 8'h00; 15: return 8'h01;
            16: return 8'h08; 17: return 8'h00; 18: return 8'h06; 19: return 8'h04;
            20: return 8'h00; 21: return op;
            default: ;
        endcase
        if (i < 28) return smac[8*(27-i) +: 8];
        if (i < 32) return sip[8*(31-i) +: 8];
        if (i < 38) return exp_mac[8*(37-i) +: 8];
        if (i < 42) return exp_lip[8*(41-i) +: 8];
        return 8'h5A;
    endfunction

    // Transmit monitor and backpressure, all at the falling edge
    always @(negedge clk) begin
        cyc++;
        tx_ready_i = rand_ready ? ($urandom % 4 != 0) : 1'b1;
        if (tx_valid_o) begin
            if (!in_frame) begin
                in_frame = 1; frames_seen++; frame_bad = 0;
                last_gap = cyc - last_end_cyc;
            end
            if (tx_ready_i) begin
                for (int k = 0; k < 8; k++)
                    if (tx_keep_o[k] && tx_data_o[8*k +: 8] != req_byte(8*mon_beat + k)) frame_bad = 1;
                if (tx_keep_o != ((mon_beat == 5) ? 8'h03 : 8'hFF)) frame_bad = 1;
                if (tx_first_o != (mon_beat == 0) || tx_last_o != (mon_beat == 5)) frame_bad = 1;
                if (tx_last_o || mon_beat == 5) begin
                    chk(!frame_bad, "R4 request frame layout (R3 target bytes 38-41)", 64'(frame_bad), 64'd0);
                    in_frame = 0; mon_beat = 0; frames_done++; last_end_cyc = cyc;
                end else begin
                    mon_beat++;
                end
            end
        end
        if (cyc > 150000 && !finished) begin
            n_chk++; n_fail++;
            $display("FAIL R2 watchdog expired act=%0d exp=<150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            finished = 1;
            $finish;
        end
    end

    task automatic kick(input logic [47:0] mac, input logic [31:0] lip, input logic [31:0] rip,
                        input int plen, input logic [31:0] gw);
        local_mac_i = mac; local_ip_i = lip; remote_ip_i = rip;
        prefix_len_i = 5'(plen); gateway_ip_i = gw;
        exp_mac = mac; exp_lip = lip; exp_tip = pick_target(lip, rip, plen, gw);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic send_reply(input logic [47:0] smac, input logic [31:0] sip, input logic [7:0] op,
                              input bit err, input int nbytes);
        int nb;
        nb = (nbytes + 7) / 8;
        for (int b = 0; b < nb; b++) begin
            int r;
            r = nbytes - 8*b;
            rx_valid_i = 1'b1;
            rx_last_i  = (b == nb - 1);
            rx_error_i = err && (b == nb - 1);
            rx_keep_i  = (r >= 8) ? 8'hFF : 8'((1 << r) - 1);
            for (int k = 0; k < 8; k++)
                rx_data_i[8*k +: 8] = (8*b + k < nbytes) ? rep_byte(8*b + k, smac, sip, op) : 8'h00;
            @(negedge clk);
        end
        rx_valid_i = 1'b0; rx_last_i = 1'b0; rx_error_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_done_frames(input int n);
        while (frames_done < n) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int base;
        logic [47:0] pmac;
        void'($urandom(32'h5EED_0A2B));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!tx_valid_o && !done_o && !busy_o && !status_valid_o, "R1 reset outputs idle",
            {tx_valid_o, done_o, busy_o, status_valid_o}, 0);
        chk(peer_mac_o == 0, "R1 reset peer mac", peer_mac_o, 0);

        // Local subnet target, near-miss replies, start while busy
        base = frames_done;
        kick(48'h02_11_22_33_44_55, 32'h0A00_0005, 32'h0A00_0009, 24, 32'h0A00_0001);
        chk(busy_o && !done_o, "R2 busy after start", {busy_o, done_o}, 2'b10);
        wait_done_frames(base + 1);
        pmac = 48'hA0_B1_C2_D3_E4_F5;
        send_reply(pmac, exp_tip ^ 32'h1, 8'h02, 0, 42);
        chk(!done_o, "R7 wrong sender IP ignored", done_o, 0);
        send_reply(pmac, exp_tip, 8'h02, 1, 42);
        chk(!done_o, "R7 errored frame ignored", done_o, 0);
        send_reply(pmac, exp_tip, 8'h01, 0, 42);
        chk(!done_o, "R7 opcode 1 ignored", done_o, 0);
        base = frames_seen;
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        repeat (20) @(negedge clk);
        chk(frames_seen == base && busy_o, "R2 start while busy ignored", frames_seen, base);
        send_reply(pmac, exp_tip, 8'h02, 0, 42);
        chk(done_o && !busy_o, "R6 reply accepted", {done_o, busy_o}, 2'b10);
        chk(peer_mac_o == pmac, "R6 learned mac", peer_mac_o, pmac);

        // Off-subnet via gateway, with one timeout and retransmission
        base = frames_done;
        kick(48'h02_AA_BB_CC_DD_01, 32'hC0A8_010A, 32'hAC10_0007, 24, 32'hC0A8_0101);
        chk(!done_o, "R2 done cleared on restart", done_o, 0);
        wait_done_frames(base + 1);
        send_reply(48'h11_11_11_11_11_11, 32'hAC10_0007, 8'h02, 0, 42);
        chk(!done_o, "R3 reply from remote ignored when gateway chosen", done_o, 0);
        wait_done_frames(base + 2);
        chk(last_gap == T + 1, "R8 retransmit spacing", last_gap, T + 1);
        pmac = 48'h00_1B_21_9C_4E_77;
        send_reply(pmac, 32'hC0A8_0101, 8'h02, 0, 60);
        chk(done_o && peer_mac_o == pmac, "R3 gateway reply accepted", peer_mac_o, pmac);

        // Prefix 0 counts as off-subnet
        base = frames_done;
        kick(48'h02_00_00_00_00_02, 32'h0A0A_0A0A, 32'h0A0A_0A0A, 0, 32'h0A0A_0A01);
        wait_done_frames(base + 1);
        send_reply(48'h22_22_22_22_22_22, 32'h0A0A_0A0A, 8'h02, 0, 42);
        chk(!done_o, "R3 prefix 0 still routes via gateway", done_o, 0);
        send_reply(48'h33_33_33_33_33_33, 32'h0A0A_0A01, 8'h02, 0, 42);
        chk(done_o && peer_mac_o == 48'h33_33_33_33_33_33, "R3 prefix 0 gateway reply", peer_mac_o, 48'h333333333333);
        base = frames_done;
        kick(48'h02_00_00_00_00_03, 32'h0A0A_0A0A, 32'h0B0B_0B0B, 0, 32'h0);
        wait_done_frames(base + 1);
        send_reply(48'h44_44_44_44_44_44, 32'h0B0B_0B0B, 8'h02, 0, 42);
        chk(done_o && peer_mac_o == 48'h44_44_44_44_44_44, "R3 no gateway targets remote", peer_mac_o, 48'h444444444444);

        // Give-up path: no reply at all
        base = frames_done;
        kick(48'h02_0F_0F_0F_0F_0F, 32'h0A01_0203, 32'h0A01_4D4D, 16, 32'h0);
        while (!status_valid_o) @(negedge clk);
        chk(status_o == 16'h0002, "R9 unreachable code", status_o, 16'h0002);
        chk(frames_done - base == RETRIES + 1, "R9 request count", frames_done - base, RETRIES + 1);
        @(negedge clk);
        chk(!status_valid_o && !busy_o && !done_o, "R9 one-cycle strobe, idle after",
            {status_valid_o, busy_o, done_o}, 0);

        // Random configurations with backpressure
        rand_ready = 1;
        for (int it = 0; it < 8; it++) begin
            logic [31:0] lip, rip, gw;
            int plen, nbytes;
            lip  = $urandom;
            rip  = ($urandom % 2) ? {lip[31:12], 12'($urandom)} : $urandom;
            plen = $urandom_range(31, 0);
            gw   = ($urandom % 2) ? $urandom : 32'h0;
            pmac = {$urandom, 16'($urandom)};
            nbytes = 42 + $urandom_range(22, 0);
            base = frames_done;
            kick({$urandom, 16'($urandom)}, lip, rip, plen, gw);
            wait_done_frames(base + 1);
            send_reply(pmac, exp_tip, 8'h02, 0, nbytes);
            chk(done_o && peer_mac_o == pmac, "R5 R6 random config resolved", peer_mac_o, pmac);
        end
        rand_ready = 0;

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule